// File: doc/BRIEF.md
# SGMII Link Bring-Up Sequencer

This block brings one SGMII port from an unknown state to a configured link without software polling. Software presents a link-mode code and pulses `start`. The sequencer then masters a small register bus. It soft-resets the port's PCS registers and clears the control register. It waits for the SerDes PLL to report lock, loads the advertised-ability and control words for the chosen mode, and waits for the link to come up. When the chosen control word enables auto-negotiation, it also waits for auto-negotiation to complete.

Both waiting phases are bounded polls. A programmable idle gap separates successive status reads, and each phase has its own gap value. If lock never appears, the sequence still continues and a flag records the failure. If the link never appears, the sequence ends and a timeout flag records it. A mode code outside the table is refused at once, and no bus traffic is issued.

The states are named as follows:
- `ST_IDLE`: accepts `start`.
- `ST_SR_READ`, `ST_SR_SET` and `ST_SR_POLL`: the soft-reset read-modify-write and its completion poll.
- `ST_CTL_ZERO`: clears the control register.
- `ST_LOCK_WAIT` and `ST_LOCK_READ`: the lock-phase gap and the lock-phase status read.
- `ST_ADV_WRITE` and `ST_CTL_WRITE`: write the ability word and the control word.
- `ST_LINK_WAIT` and `ST_LINK_READ`: the link-phase gap and the link-phase status read.
- `ST_FINISH`: the one-cycle completion state.

The transitions are as follows:
- `ST_IDLE` goes to `ST_SR_READ` on a valid start, or to `ST_FINISH` on an invalid one.
- Each bus state advances on `bus_ack`. `ST_SR_POLL` advances only on the acknowledge that returns bit 0 clear.
- `ST_CTL_ZERO` goes to `ST_LOCK_WAIT`.
- A wait state goes to its read state when its gap counter reaches zero.
- A failed read returns to its wait state until the attempt budget is spent.
- `ST_LOCK_READ` goes to `ST_ADV_WRITE`, then `ST_CTL_WRITE`, then `ST_LINK_WAIT`.
- `ST_LINK_READ` goes to `ST_FINISH`.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `sgmii_bringup_seq`

## Requirements
- R1: A synchronous active-high `rst` returns the sequencer to idle in the cycle after the edge, with `busy`, `done`, `bus_req`, `err_mode`, `pll_nolock` and `link_tmo` all low.
- R2: The soft reset reads offset 0x04, writes the value read back to offset 0x04 with bit 0 set and every other bit preserved, then reads offset 0x04 repeatedly until bit 0 reads as zero.
- R3: Mode codes select these (advertise, control) pairs. Code 0, MAC-to-MAC negotiated: (0x9801, 0x0021). Codes 1 and 2, MAC-to-PHY with or without management: (0x0001, 0x0001). Code 3, MAC-to-MAC forced: (0x9801, 0x0020). Code 4, fiber: (0x0020, 0x0001).
- R4: A start with mode code 5, 6 or 7 raises `done` and `err_mode` in the next cycle and issues no bus transaction.
- R5: Offset 0x10 (control) is written with zero after the soft reset completes and before the first status read.
- R6: The lock poll reads offset 0x14 and tests bit 4. The first read and each retry come exactly `lock_gap`+2 cycles after the previous acknowledge. There are at most POLL_MAX reads. If bit 4 is still clear on the last read, `pll_nolock` is set and the sequence continues.
- R7: The advertised-ability word is written to offset 0x18 before the control word is written to offset 0x10.
- R8: The link poll reads offset 0x14, spaced `link_gap`+2 cycles apart, and succeeds when bit 0 is set. When control bit 0 is set, it also requires bit 2. After POLL_MAX failed reads, `link_tmo` is set and `done` is still raised.
- R9: `busy` is high in every cycle from the one after an accepted start until `done`. `done` is a one-cycle pulse with `busy` low. The three flags hold their values until the next accepted start clears them.
- R10: A start while busy is ignored. The mode in use is the one sampled when the start was accepted.
- R11: A bus request keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stable until `bus_ack`. Read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up sequence (accepted only when idle) |
| mode | input | 3 | Link-mode code, sampled with start |
| lock_gap | input | WAIT_W | Idle cycles minus one between lock-phase status reads |
| link_gap | input | WAIT_W | Idle cycles minus one between link-phase status reads |
| bus_req | output | 1 | Register-bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register offset within the port |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Register-bus acknowledge |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_mode | output | 1 | Last start carried an unsupported mode |
| pll_nolock | output | 1 | Lock poll exhausted without lock |
| link_tmo | output | 1 | Link poll exhausted without link |

## Verification
Two functions can act on the same status read: a phase that succeeds and the attempt budget that runs out. Lock or link may appear on exactly the final permitted read, and that cycle must count as success, not timeout. The bench provokes this by programming the status model so that lock, link or auto-negotiation first reads as set on read POLL_MAX, and one read later in other cases. It then judges at the ports that the flag stays clear and that exactly POLL_MAX status reads occurred. A second collision, a start arriving mid-sequence with a different or illegal mode, is judged by the words that reach offsets 0x18 and 0x10 and by `err_mode`.

// File: rtl/sgb_pkg.sv
package sgb_pkg;

    localparam int MODE_W = 3;

    // register offsets inside one port
    localparam logic [7:0] OFS_SRST = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_ADV  = 8'h18;

    // bit positions decoded by the sequencer
    localparam int SRST_GO_BIT   = 0;
    localparam int STAT_LINK_BIT = 0;
    localparam int STAT_AN_BIT   = 2;
    localparam int STAT_LOCK_BIT = 4;
    localparam int CTRL_AN_BIT   = 0;

    typedef enum logic [MODE_W-1:0] {
        MD_MAC_MAC_NEG  = 3'd0,
        MD_MAC_PHY      = 3'd1,
        MD_MAC_PHY_NOMG = 3'd2,
        MD_MAC_MAC_FIX  = 3'd3,
        MD_FIBER        = 3'd4
    } link_mode_e;

    typedef struct packed {
        logic        valid;
        logic [15:0] adv;
        logic [15:0] ctl;
    } mode_cfg_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SR_READ,
        ST_SR_SET,
        ST_SR_POLL,
        ST_CTL_ZERO,
        ST_LOCK_WAIT,
        ST_LOCK_READ,
        ST_ADV_WRITE,
        ST_CTL_WRITE,
        ST_LINK_WAIT,
        ST_LINK_READ,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/sgb_mode_table.sv
module sgb_mode_table
    import sgb_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_cfg_t         cfg
);

    always_comb begin
        cfg = '0;
        case (mode)
            MD_MAC_MAC_NEG: cfg = '{valid: 1'b1, adv: 16'h9801, ctl: 16'h0021};
            MD_MAC_PHY,
            MD_MAC_PHY_NOMG: cfg = '{valid: 1'b1, adv: 16'h0001, ctl: 16'h0001};
            MD_MAC_MAC_FIX: cfg = '{valid: 1'b1, adv: 16'h9801, ctl: 16'h0020};
            MD_FIBER:       cfg = '{valid: 1'b1, adv: 16'h0020, ctl: 16'h0001};
            default:        cfg = '0;
        endcase
    end

endmodule

// File: rtl/sgb_pace.sv
module sgb_pace #(
    parameter int WAIT_W   = 16,
    parameter int POLL_MAX = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wait_load,
    input  logic [WAIT_W-1:0] wait_val,
    input  logic              wait_dec,
    output logic              wait_zero,
    input  logic              try_clr,
    input  logic              try_inc,
    output logic              try_last
);

    localparam int TRY_W = $clog2(POLL_MAX + 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_MAX - 1);

    logic [WAIT_W-1:0] wait_cnt;
    logic [TRY_W-1:0]  try_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
        end else if (wait_load) begin
            wait_cnt <= wait_val;
        end else if (wait_dec && wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            try_cnt <= '0;
        end else if (try_clr) begin
            try_cnt <= '0;
        end else if (try_inc && try_cnt != TRY_LAST) begin
            try_cnt <= try_cnt + 1'b1;
        end
    end

    assign wait_zero = (wait_cnt == '0);
    assign try_last  = (try_cnt == TRY_LAST);

    // attempt count never passes the budget (R6 / R8)
    p_try_bound_r6: assert property (@(posedge clk) disable iff (rst)
        try_cnt <= TRY_LAST);

    // a fresh load reaches the counter exactly (R8 spacing)
    p_wait_load_r8: assert property (@(posedge clk) disable iff (rst)
        wait_load |=> wait_cnt == $past(wait_val));

endmodule

// File: rtl/sgmii_bringup_seq.sv
module sgmii_bringup_seq
    import sgb_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int WAIT_W   = 16,
    parameter int POLL_MAX = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [WAIT_W-1:0] lock_gap,
    input  logic [WAIT_W-1:0] link_gap,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              err_mode,
    output logic              pll_nolock,
    output logic              link_tmo
);

    localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(OFS_SRST);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_ADV  = ADDR_W'(OFS_ADV);
    localparam logic [DATA_W-1:0] SRST_GO = DATA_W'(1) << SRST_GO_BIT;

    seq_state_e        st_q, st_d;
    mode_cfg_t         tbl_cfg, cfg_q;
    logic [DATA_W-1:0] srst_q;
    logic              accept;
    logic              lock_seen, link_ok;
    logic              wait_load, wait_dec, wait_zero;
    logic              try_clr, try_inc, try_last;
    logic [WAIT_W-1:0] wait_val;

    sgb_mode_table u_table (
        .mode (mode),
        .cfg  (tbl_cfg)
    );

    sgb_pace #(
        .WAIT_W   (WAIT_W),
        .POLL_MAX (POLL_MAX)
    ) u_pace (
        .clk       (clk),
        .rst       (rst),
        .wait_load (wait_load),
        .wait_val  (wait_val),
        .wait_dec  (wait_dec),
        .wait_zero (wait_zero),
        .try_clr   (try_clr),
        .try_inc   (try_inc),
        .try_last  (try_last)
    );

    assign accept    = (st_q == ST_IDLE) && start;
    assign lock_seen = bus_rdata[STAT_LOCK_BIT];
    assign link_ok   = bus_rdata[STAT_LINK_BIT] &&
                       (!cfg_q.ctl[CTRL_AN_BIT] || bus_rdata[STAT_AN_BIT]);
    assign wait_val  = (st_q == ST_CTL_ZERO || st_q == ST_LOCK_READ) ? lock_gap : link_gap;

    // next-state and pacing controls
    always_comb begin
        st_d      = st_q;
        wait_load = 1'b0;
        wait_dec  = 1'b0;
        try_clr   = 1'b0;
        try_inc   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) st_d = tbl_cfg.valid ? ST_SR_READ : ST_FINISH;
            end
            ST_SR_READ: begin
                if (bus_ack) st_d = ST_SR_SET;
            end
            ST_SR_SET: begin
                if (bus_ack) st_d = ST_SR_POLL;
            end
            ST_SR_POLL: begin
                if (bus_ack && !bus_rdata[SRST_GO_BIT]) st_d = ST_CTL_ZERO;
            end
            ST_CTL_ZERO: begin
                if (bus_ack) begin
                    st_d      = ST_LOCK_WAIT;
                    wait_load = 1'b1;
                    try_clr   = 1'b1;
                end
            end
            ST_LOCK_WAIT: begin
                if (wait_zero) st_d = ST_LOCK_READ;
                else           wait_dec = 1'b1;
            end
            ST_LOCK_READ: begin
                if (bus_ack) begin
                    if (lock_seen || try_last) begin
                        st_d = ST_ADV_WRITE;
                    end else begin
                        st_d      = ST_LOCK_WAIT;
                        wait_load = 1'b1;
                        try_inc   = 1'b1;
                    end
                end
            end
            ST_ADV_WRITE: begin
                if (bus_ack) st_d = ST_CTL_WRITE;
            end
            ST_CTL_WRITE: begin
                if (bus_ack) begin
                    st_d      = ST_LINK_WAIT;
                    wait_load = 1'b1;
                    try_clr   = 1'b1;
                end
            end
            ST_LINK_WAIT: begin
                if (wait_zero) st_d = ST_LINK_READ;
                else           wait_dec = 1'b1;
            end
            ST_LINK_READ: begin
                if (bus_ack) begin
                    if (link_ok || try_last) begin
                        st_d = ST_FINISH;
                    end else begin
                        st_d      = ST_LINK_WAIT;
                        wait_load = 1'b1;
                        try_inc   = 1'b1;
                    end
                end
            end
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // latched mode, captured soft-reset word and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            srst_q     <= '0;
            err_mode   <= 1'b0;
            pll_nolock <= 1'b0;
            link_tmo   <= 1'b0;
        end else if (accept) begin
            cfg_q      <= tbl_cfg;
            err_mode   <= !tbl_cfg.valid;
            pll_nolock <= 1'b0;
            link_tmo   <= 1'b0;
        end else begin
            if (st_q == ST_SR_READ && bus_ack) srst_q <= bus_rdata;
            if (st_q == ST_LOCK_READ && bus_ack && !lock_seen && try_last) pll_nolock <= 1'b1;
            if (st_q == ST_LINK_READ && bus_ack && !link_ok && try_last)   link_tmo   <= 1'b1;
        end
    end

    // bus and handshake outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        busy      = (st_q != ST_IDLE) && (st_q != ST_FINISH);
        done      = (st_q == ST_FINISH);
        unique case (st_q)
            ST_SR_READ, ST_SR_POLL: begin
                bus_req  = 1'b1;
                bus_addr = A_SRST;
            end
            ST_SR_SET: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_SRST;
                bus_wdata = srst_q | SRST_GO;
            end
            ST_CTL_ZERO: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = A_CTRL;
            end
            ST_LOCK_READ, ST_LINK_READ: begin
                bus_req  = 1'b1;
                bus_addr = A_STAT;
            end
            ST_ADV_WRITE: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_ADV;
                bus_wdata = DATA_W'(cfg_q.adv);
            end
            ST_CTL_WRITE: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = A_CTRL;
                bus_wdata = DATA_W'(cfg_q.ctl);
            end
            default: ;
        endcase
    end

    // an unacknowledged request stays put (R11)
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // no traffic outside a sequence (R9)
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);

    // completion is a single pulse (R9)
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // illegal mode finishes immediately with error and no traffic (R4)
    p_bad_mode_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && start && !tbl_cfg.valid) |=> done && err_mode && !bus_req);

    // a start while busy cannot alter the error flag (R10)
    p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(err_mode));

    // the advertise write is always followed by a control write (R7)
    p_adv_then_ctl_r7: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && bus_addr == A_ADV && bus_ack |=> bus_req && bus_we && bus_addr == A_CTRL);

endmodule

// File: tb/sim_sgmii_bringup_seq.sv
module sim_sgmii_bringup_seq;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int WAIT_W = 8;
    localparam int PMAX   = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [2:0]        mode_i = '0;
    logic [WAIT_W-1:0] lock_gap = '0;
    logic [WAIT_W-1:0] link_gap = '0;
    logic              bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_ack = 1'b0;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic              busy, done, err_mode, pll_nolock, link_tmo;

    always #5 clk = ~clk;

    sgmii_bringup_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .POLL_MAX(PMAX)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode_i),
        .lock_gap(lock_gap), .link_gap(link_gap),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .err_mode(err_mode),
        .pll_nolock(pll_nolock), .link_tmo(link_tmo)
    );

    int total = 0;
    int bad   = 0;

    // register-model state
    int          cyc = 0;
    int          lat = 0;
    bit          fresh = 1'b1;
    logic [31:0] srst_val;
    int          srst_hold, rst_busy;
    int          lock_n, link_n, an_n;
    bit          in_link;
    int          lock_rd, link_rd, srst_rd, rd_other;
    int          wcount;
    logic [7:0]  wl_addr [0:15];
    logic [31:0] wl_data [0:15];
    bit          prev_stat;
    int          last_stat_cyc;
    int          gap_bad;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit mode_ok(input int m);
        return m <= 4;
    endfunction
    function automatic logic [31:0] exp_adv(input int m);
        case (m)
            0, 3: return 32'h9801;
            1, 2: return 32'h0001;
            4: return 32'h0020;
            default: return 32'h0;
        endcase
    endfunction
    function automatic logic [31:0] exp_ctl(input int m);
        case (m)
            0: return 32'h0021;
            3: return 32'h0020;
            1, 2, 4: return 32'h0001;
            default: return 32'h0;
        endcase
    endfunction
    function automatic int reads_for(input int need);
        return (need < PMAX) ? need + 1 : PMAX;
    endfunction

    task automatic serve();
        logic [31:0] d;
        if (bus_we) begin
            if (wcount < 16) begin
                wl_addr[wcount] = bus_addr;
                wl_data[wcount] = bus_wdata;
            end
            wcount++;
            if (bus_addr == 8'h04) begin
                srst_val  = bus_wdata & ~32'h1;
                srst_hold = rst_busy;
            end
            if (bus_addr == 8'h18) in_link = 1'b1;
            prev_stat = 1'b0;
        end else if (bus_addr == 8'h04) begin
            srst_rd++;
            d = srst_val | ((srst_hold > 0) ? 32'h1 : 32'h0);
            if (srst_hold > 0) srst_hold--;
            bus_rdata = d;
            prev_stat = 1'b0;
        end else if (bus_addr == 8'h14) begin
            d = $urandom & 32'hFFFF_FFEA;
            if (!in_link) begin
                if (lock_rd >= lock_n) d[4] = 1'b1;
                lock_rd++;
            end else begin
                d[4] = 1'b1;
                if (link_rd >= link_n) d[0] = 1'b1;
                if (link_rd >= an_n)   d[2] = 1'b1;
                link_rd++;
            end
            bus_rdata = d;
            prev_stat = 1'b1;
            last_stat_cyc = cyc;
        end else begin
            rd_other++;
            bus_rdata = $urandom;
        end
    endtask

    // register-bus responder with random acknowledge latency
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (bus_ack) begin
                bus_ack = 1'b0;
                lat = $urandom % 3;
                fresh = 1'b1;
            end else if (bus_req) begin
                if (fresh) begin
                    fresh = 1'b0;
                    if (prev_stat && !bus_we && bus_addr == 8'h14) begin
                        if (cyc - last_stat_cyc != (in_link ? int'(link_gap) : int'(lock_gap)) + 2)
                            gap_bad++;
                    end
                end
                if (lat == 0) begin
                    serve();
                    bus_ack = 1'b1;
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic prep(input int ln, input int kn, input int an, input int rb, input logic [31:0] sinit);
        lock_n = ln; link_n = kn; an_n = an; rst_busy = rb;
        srst_val = sinit & ~32'h1; srst_hold = 0; in_link = 1'b0;
        lock_rd = 0; link_rd = 0; srst_rd = 0; rd_other = 0; wcount = 0;
        prev_stat = 1'b0; gap_bad = 0;
    endtask

    task automatic run_case(input int m, input int ln, input int kn, input int an,
                            input int lg, input int kg, input int rb,
                            input logic [31:0] sinit, input int intr_mode);
        int need, waited;
        logic [31:0] s0;
        bit busy_ok;
        prep(ln, kn, an, rb, sinit);
        s0 = sinit & ~32'h1;
        @(negedge clk);
        mode_i = 3'(m); lock_gap = WAIT_W'(lg); link_gap = WAIT_W'(kg); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!mode_ok(m)) begin
            chk(done && err_mode && !busy, "R4 immediate done+err", {done, err_mode, busy}, 3'b110);
            @(negedge clk);
            chk(wcount == 0 && srst_rd == 0 && lock_rd == 0 && rd_other == 0,
                "R4 no bus traffic", wcount + srst_rd + lock_rd, 0);
            return;
        end
        chk(busy && !done && !err_mode && !pll_nolock && !link_tmo, "R9 start clears flags, busy",
            {busy, done, err_mode, pll_nolock, link_tmo}, 5'b10000);
        busy_ok = 1'b1;
        waited = 0;
        if (intr_mode >= 0) begin
            repeat (3) @(negedge clk);
            mode_i = 3'(intr_mode); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && waited < 20000) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            waited++;
        end
        chk(done, "R9 done reached", done, 1);
        chk(busy_ok && !busy, "R9 busy until done", busy_ok, 1);
        chk(!err_mode, "R10 no error from valid start", err_mode, 0);
        chk(srst_rd == rb + 2, "R2 soft-reset reads", srst_rd, rb + 2);
        chk(wcount == 4, "R5 write count", wcount, 4);
        chk(wl_addr[0] == 8'h04 && wl_data[0] == (s0 | 32'h1), "R2 RMW write", wl_data[0], s0 | 32'h1);
        chk(wl_addr[1] == 8'h10 && wl_data[1] == 32'h0, "R5 control cleared first", {wl_addr[1], wl_data[1]}, 40'h10_0000_0000);
        chk(wl_addr[2] == 8'h18 && wl_data[2] == exp_adv(m), "R3 R7 R10 advertise word", wl_data[2], exp_adv(m));
        chk(wl_addr[3] == 8'h10 && wl_data[3] == exp_ctl(m), "R3 R7 R10 control word", wl_data[3], exp_ctl(m));
        chk(lock_rd == reads_for(ln), "R6 lock reads", lock_rd, reads_for(ln));
        chk(pll_nolock == (ln >= PMAX), "R6 nolock flag", pll_nolock, ln >= PMAX);
        need = exp_ctl(m)[0] ? ((kn > an) ? kn : an) : kn;
        chk(link_rd == reads_for(need), "R8 link reads", link_rd, reads_for(need));
        chk(link_tmo == (need >= PMAX), "R8 timeout flag", link_tmo, need >= PMAX);
        chk(gap_bad == 0, "R6 R8 poll spacing", gap_bad, 0);
        @(negedge clk);
        chk(!done && !busy, "R9 done is one pulse", done, 0);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_req && !err_mode && !pll_nolock && !link_tmo,
            "R1 reset state", {busy, done, bus_req, err_mode, pll_nolock, link_tmo}, 0);
        rst = 1'b0;

        // every legal mode, directed, with no faults
        for (int m = 0; m < 5; m++) run_case(m, 1, 2, 1, 1, 0, 1, 32'h2, -1);
        // illegal modes
        for (int m = 5; m < 8; m++) run_case(m, 0, 0, 0, 0, 0, 0, 32'h0, -1);
        // lock lands on the very last attempt, then never locks
        run_case(0, PMAX - 1, PMAX - 1, PMAX - 1, 2, 1, 0, 32'h0, -1);
        run_case(4, PMAX, 0, 0, 0, 3, 2, 32'h6, -1);
        // flags hold after done
        repeat (3) @(negedge clk);
        chk(pll_nolock && !done, "R9 flag holds after done", pll_nolock, 1);
        // auto-negotiation missing only matters when enabled
        run_case(3, 0, 1, 50, 1, 1, 0, 32'h0, -1);
        run_case(1, 0, 1, PMAX, 1, 1, 0, 32'h0, -1);
        // start while busy, with another mode and an illegal one
        run_case(4, 2, 2, 0, 2, 2, 1, 32'h0, 0);
        run_case(3, 1, 1, 0, 1, 1, 1, 32'h0, 7);

        // random mix
        for (int i = 0; i < 25; i++) begin
            run_case($urandom % 8, $urandom % (PMAX + 3), $urandom % (PMAX + 3), $urandom % (PMAX + 3),
                     $urandom % 5, $urandom % 5, $urandom % 4, $urandom & 32'h0000_00FE, -1);
        end

        // reset in the middle of a sequence
        prep(PMAX, PMAX, PMAX, 0, 32'h0);
        @(negedge clk);
        mode_i = 3'd0; lock_gap = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !done && !bus_req && !pll_nolock && !link_tmo && !err_mode,
            "R1 mid-run reset", {busy, done, bus_req}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule